// File: doc/BRIEF.md
# Byte-Wide Command Bus Host Controller

This block is the host side of a chip-select framed, SPI-like bus that carries one byte on every clock over eight data lines. For each transfer it pulls chip select low, then drives a fixed 16-byte command that it reads from a command buffer. Right behind the command it sends a CRC-32 of those bytes. After that it releases the lines and lets a two-cycle turnaround pass. It then reads a one-byte status from the device.

If the status is accepted, the host keeps clocking while the device holds data line 0 low to show it is busy. It waits for a ready marker, which is two consecutive cycles with data line 0 high. It then captures a response whose length software has programmed, and checks the CRC-32 that follows it. The response bytes go out as a valid/data stream. When the transfer ends, a one-cycle done pulse is raised, along with one of three outcome flags: command rejected, response CRC error, or busy timeout.

The CRC is the reflected CRC-32. It uses polynomial 0xEDB88320, starts from all ones and inverts the final value. It is computed one byte per clock and sent least-significant byte first. The pads, the bus clock and the meaning of the command bytes are handled outside this block.

Top module: `cmdbus_host`

## Requirements
- R1: After reset, csN is high, busOe is low, and done, rejected, crcErr and timeout are all low.
- R2: A start seen while idle opens a transfer in the next cycle. For exactly 20 cycles, csN is low and busOe is high. busOut carries command bytes 0 to 15 in index order, then the 4 bytes of the CRC-32 over those 16 bytes, least-significant byte first.
- R3: From the 21st cycle of a transfer until csN rises, busOe is low. The first two of those cycles are turnaround cycles, and the host ignores busIn during them.
- R4: The host samples busIn in the 23rd cycle of the transfer as the status byte. The value 0x00 accepts the command. Any other value (the device uses 0x01 for a bad command CRC) ends the transfer: csN goes high in the next cycle, rejected is set and no response byte is delivered.
- R5: After an accepted status, only bit 0 of busIn is observed. The ready marker is bit 0 high in two consecutive cycles. A single high cycle followed by a low cycle does not count. The first response byte is sampled in the cycle after the marker.
- R6: Exactly rspLen bytes are captured (rspLen of 0 means none). Each byte appears on rspData with rspValid high, in bus order, in the cycle after it was on the bus.
- R7: The 4 bytes after the response are read as a CRC-32 over the response bytes only, least-significant byte first. csN rises in the cycle after the last of them, and crcErr is set when they do not match.
- R8: The busy wait lasts at most busyLimit cycles, counted from the cycle after the status. If the marker has not completed within that window, csN rises, timeout is set and no response byte is delivered. busyLimit must be at least 2.
- R9: done is high for exactly one cycle, in the first cycle that csN is high after a transfer. The outcome flags hold their value until the next transfer is accepted, which clears them.
- R10: A start while a transfer is in progress has no effect on that transfer, and it does not open another one after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transfer (taken only when idle) |
| rspLen | input | LEN_W | Number of response bytes expected |
| busyLimit | input | TO_W | Maximum busy-wait cycles before abort |
| cmdRdIdx | output | 4 | Command buffer read index |
| cmdRdData | input | 8 | Command buffer byte at cmdRdIdx (same cycle) |
| csN | output | 1 | Chip select, active low |
| busOut | output | 8 | Byte driven to the data lines |
| busOe | output | 1 | Output enable for the data lines |
| busIn | input | 8 | Byte read from the data lines |
| rspValid | output | 1 | rspData holds a response byte |
| rspData | output | 8 | Captured response byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rejected | output | 1 | Status byte was not 0x00 |
| crcErr | output | 1 | Response CRC mismatch |
| timeout | output | 1 | Ready marker did not arrive in time |

## Verification
The assertions rely on three assumptions. First, start may be asserted at any time. Second, rspLen and busyLimit stay fixed while a transfer is running. Third, busyLimit is at least 2, so the busy window cannot wrap. The bench changes rspLen and busyLimit only between transfers and never sets busyLimit below 11. It drives busIn from a device model that is timed to the chip-select cycle count. That model places pull-up ones in the turnaround cycles, uses busy bytes with every bit high except bit 0, and includes a one-cycle false marker. This exercises the bit-0-only rule without breaking any assertion premise.

// File: rtl/cmdbus_pkg.sv
package cmdbus_pkg;

  localparam int CMD_BYTES   = 16;
  localparam int CRC_BYTES   = 4;
  localparam int TURN_CYCLES = 2;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_TURN,
    ST_STAT,
    ST_WAIT,
    ST_DATA,
    ST_RCRC
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       crcInit;
    logic       crcTx;
    logic       crcRx;
    logic       txFromCmd;
    logic [1:0] crcByteSel;
    logic       rspCapture;
    logic       rxCrcShift;
  } dpStrobe_t;

  function automatic logic [31:0] crcStep(input logic [31:0] cur, input logic [7:0] din);
    logic [31:0] acc;
    acc = cur ^ {24'd0, din};
    for (int i = 0; i < 8; i++) begin
      acc = acc[0] ? ((acc >> 1) ^ CRC_POLY) : (acc >> 1);
    end
    return acc;
  endfunction

endpackage

// File: rtl/cmdbus_datapath.sv
module cmdbus_datapath
  import cmdbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic [7:0] cmdRdData,
  input  logic [7:0] busIn,
  output logic [7:0] busOut,
  output logic       rspValid,
  output logic [7:0] rspData,
  output logic       crcMatch
);

  logic [31:0] crcReg;
  logic [31:0] crcOut;
  logic [31:0] rxCrc;

  assign crcOut = ~crcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= '1;
    end else if (stb.crcInit) begin
      crcReg <= '1;
    end else if (stb.crcTx) begin
      crcReg <= crcStep(crcReg, cmdRdData);
    end else if (stb.crcRx) begin
      crcReg <= crcStep(crcReg, busIn);
    end
  end

  // outgoing byte: command buffer, else the selected CRC byte
  always_comb begin
    if (stb.txFromCmd) begin
      busOut = cmdRdData;
    end else begin
      case (stb.crcByteSel)
        2'd0:    busOut = crcOut[7:0];
        2'd1:    busOut = crcOut[15:8];
        2'd2:    busOut = crcOut[23:16];
        default: busOut = crcOut[31:24];
      endcase
    end
  end

  // received CRC shifts in from the top, least-significant byte first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCrc <= '0;
    end else if (stb.rxCrcShift) begin
      rxCrc <= {busIn, rxCrc[31:8]};
    end
  end

  assign crcMatch = ({busIn, rxCrc[31:8]} == crcOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= stb.rspCapture;
      if (stb.rspCapture) rspData <= busIn;
    end
  end

  // R6: a captured byte is never produced from a CRC-shift cycle
  p_capture_not_crc_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !$past(stb.rxCrcShift));

endmodule

// File: rtl/cmdbus_ctrl.sv
module cmdbus_ctrl
  import cmdbus_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] rspLen,
  input  logic [TO_W-1:0]  busyLimit,
  input  logic [7:0]       busIn,
  input  logic             crcMatch,
  output dpStrobe_t        stb,
  output logic [3:0]       cmdRdIdx,
  output logic             csN,
  output logic             busOe,
  output logic             done,
  output logic             rejected,
  output logic             crcErr,
  output logic             timeout
);

  localparam int CNT_W = (LEN_W > 5) ? LEN_W : 5;
  localparam logic [CNT_W-1:0] CMD_END  = CNT_W'(CMD_BYTES + CRC_BYTES - 1);
  localparam logic [CNT_W-1:0] CMD_DATA = CNT_W'(CMD_BYTES);
  localparam logic [CNT_W-1:0] TURN_END = CNT_W'(TURN_CYCLES - 1);
  localparam logic [CNT_W-1:0] RCRC_END = CNT_W'(CRC_BYTES - 1);

  xferState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [TO_W-1:0]  waitCnt;
  logic             hiSeen;
  logic             markerHit;
  logic [CNT_W-1:0] rspLast;

  assign markerHit = (state == ST_WAIT) && busIn[0] && hiSeen;
  assign rspLast   = CNT_W'(rspLen) - CNT_W'(1);

  assign csN      = (state == ST_IDLE);
  assign busOe    = (state == ST_CMD);
  assign cmdRdIdx = cnt[3:0];

  always_comb begin
    stb            = '0;
    stb.crcInit    = ((state == ST_IDLE) && start) || markerHit;
    stb.crcTx      = (state == ST_CMD) && (cnt < CMD_DATA);
    stb.txFromCmd  = (state == ST_CMD) && (cnt < CMD_DATA);
    stb.crcByteSel = cnt[1:0];
    stb.crcRx      = (state == ST_DATA);
    stb.rspCapture = (state == ST_DATA);
    stb.rxCrcShift = (state == ST_RCRC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      waitCnt  <= '0;
      hiSeen   <= 1'b0;
      done     <= 1'b0;
      rejected <= 1'b0;
      crcErr   <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_CMD;
            cnt      <= '0;
            rejected <= 1'b0;
            crcErr   <= 1'b0;
            timeout  <= 1'b0;
          end
        end
        ST_CMD: begin
          if (cnt == CMD_END) begin
            state <= ST_TURN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_TURN: begin
          if (cnt == TURN_END) begin
            state <= ST_STAT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STAT: begin
          if (busIn == 8'h00) begin
            state   <= ST_WAIT;
            waitCnt <= '0;
            hiSeen  <= 1'b0;
          end else begin
            state    <= ST_IDLE;
            rejected <= 1'b1;
            done     <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (markerHit) begin
            cnt   <= '0;
            state <= (rspLen == '0) ? ST_RCRC : ST_DATA;
          end else if (waitCnt == busyLimit - TO_W'(1)) begin
            state   <= ST_IDLE;
            timeout <= 1'b1;
            done    <= 1'b1;
          end else begin
            waitCnt <= waitCnt + TO_W'(1);
            hiSeen  <= busIn[0];
          end
        end
        ST_DATA: begin
          if (cnt == rspLast) begin
            state <= ST_RCRC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_RCRC: begin
          if (cnt == RCRC_END) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            crcErr <= !crcMatch;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: every rise of chip select is announced by done
  p_cs_rise_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> done);

  // R4, R7, R8: at most one outcome flag
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rejected, crcErr, timeout}));

  // R8: busy wait never runs past the programmed window
  p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (waitCnt < busyLimit));

  // R10: start while busy does not disturb an open transfer
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && start && state != ST_RCRC && state != ST_STAT && state != ST_WAIT) |=> !csN);

endmodule

// File: rtl/cmdbus_host.sv
module cmdbus_host
  import cmdbus_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] rspLen,
  input  logic [TO_W-1:0]  busyLimit,
  output logic [3:0]       cmdRdIdx,
  input  logic [7:0]       cmdRdData,
  output logic             csN,
  output logic [7:0]       busOut,
  output logic             busOe,
  input  logic [7:0]       busIn,
  output logic             rspValid,
  output logic [7:0]       rspData,
  output logic             done,
  output logic             rejected,
  output logic             crcErr,
  output logic             timeout
);

  dpStrobe_t stb;
  logic      crcMatch;

  cmdbus_ctrl #(
    .LEN_W(LEN_W),
    .TO_W (TO_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rspLen   (rspLen),
    .busyLimit(busyLimit),
    .busIn    (busIn),
    .crcMatch (crcMatch),
    .stb      (stb),
    .cmdRdIdx (cmdRdIdx),
    .csN      (csN),
    .busOe    (busOe),
    .done     (done),
    .rejected (rejected),
    .crcErr   (crcErr),
    .timeout  (timeout)
  );

  cmdbus_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cmdRdData(cmdRdData),
    .busIn    (busIn),
    .busOut   (busOut),
    .rspValid (rspValid),
    .rspData  (rspData),
    .crcMatch (crcMatch)
  );

  // R2: the bus is only driven inside a chip-select frame
  p_oe_in_frame_r2: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !csN);

  // R3: the drive is released while the frame stays open
  p_release_in_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOe) |-> !csN);

  // R6: response bytes only surface inside an open frame
  p_rsp_in_frame_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !csN);

endmodule

// File: tb/cmdbus_host_tb.sv
module cmdbus_host_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  rspLen = 8'd0;
  logic [15:0] busyLimit = 16'd20;
  logic [3:0]  cmdRdIdx;
  logic [7:0]  cmdRdData;
  logic        csN;
  logic [7:0]  busOut;
  logic        busOe;
  logic [7:0]  busIn = 8'hFF;
  logic        rspValid;
  logic [7:0]  rspData;
  logic        done;
  logic        rejected;
  logic        crcErr;
  logic        timeout;

  logic [7:0] cmdMem [0:15];
  logic [7:0] devB   [0:255];
  logic [7:0] rsp    [0:63];

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  assign cmdRdData = cmdMem[cmdRdIdx];

  cmdbus_host u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rspLen   (rspLen),
    .busyLimit(busyLimit),
    .cmdRdIdx (cmdRdIdx),
    .cmdRdData(cmdRdData),
    .csN      (csN),
    .busOut   (busOut),
    .busOe    (busOe),
    .busIn    (busIn),
    .rspValid (rspValid),
    .rspData  (rspData),
    .done     (done),
    .rejected (rejected),
    .crcErr   (crcErr),
    .timeout  (timeout)
  );

  function automatic logic [31:0] benchCrc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ d[i];
      r  = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // mode: 0 normal, 1 rejected, 2 timeout, 3 crc error
  task automatic runXfer(input logic [7:0] stat, input int busyN, input bit glitch,
                         input int len, input bit corrupt, input int limit,
                         input int seed, input bit poke, input int mode, input string req);
    logic [31:0] c;
    logic [31:0] txCrc;
    logic [31:0] rc;
    logic [7:0]  exp;
    int p, k, lowCnt, nGot, txBad, oeBad, rspBad, expLow, expGot, highBad;
    for (int i = 0; i < 16; i++) cmdMem[i] = 8'(seed * 17 + i * 5 + 3);
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 16; i++) c = benchCrc(c, cmdMem[i]);
    txCrc = ~c;
    for (int i = 0; i < 256; i++) devB[i] = 8'hFE;
    devB[20] = 8'hFF;
    devB[21] = 8'hFF;
    devB[22] = stat;
    p = 23;
    if (glitch) begin
      devB[23] = 8'hFF;
      devB[24] = 8'hFE;
      p = 25;
    end
    p = p + busyN;
    devB[p]   = 8'h5B;
    devB[p+1] = 8'h5B;
    p = p + 2;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      rsp[i] = 8'(seed + i * 29 + 1);
      devB[p+i] = rsp[i];
      c = benchCrc(c, rsp[i]);
    end
    rc = ~c;
    if (corrupt) rc = rc ^ 32'h00010000;
    for (int j = 0; j < 4; j++) devB[p+len+j] = rc[8*j +: 8];
    if (mode == 1) expLow = 23;
    else if (mode == 2) expLow = 23 + limit;
    else expLow = p + len + 4;
    expGot = (mode == 0 || mode == 3) ? len : 0;

    rspLen    = 8'(len);
    busyLimit = 16'(limit);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    k = 0; lowCnt = 0; nGot = 0; txBad = 0; oeBad = 0; rspBad = 0;
    while (!csN && k < 255) begin
      busIn = devB[k];
      if (k < 16) exp = cmdMem[k];
      else exp = txCrc[8*(k-16) +: 8];
      if (k < 20 && (busOut !== exp || busOe !== 1'b1)) txBad++;
      if (k >= 20 && busOe !== 1'b0) oeBad++;
      if (rspValid) begin
        if (nGot < 64 && rspData !== rsp[nGot]) rspBad++;
        nGot++;
      end
      if (poke && k == 5) start = 1'b1;
      if (poke && k == 6) start = 1'b0;
      lowCnt++;
      k++;
      @(negedge clk);
    end
    busIn = 8'hFF;
    chk(lowCnt == expLow, req, "frame length", lowCnt, expLow);
    if (mode != 2 || limit > 0) chk(txBad == 0, "R2", "command/CRC bytes wrong", txBad, 0);
    chk(oeBad == 0, "R3", "drive not released", oeBad, 0);
    chk(done == 1'b1, "R9", "done at frame end", int'(done), 1);
    chk(rejected == (mode == 1), "R4", "rejected flag", int'(rejected), int'(mode == 1));
    chk(timeout == (mode == 2), "R8", "timeout flag", int'(timeout), int'(mode == 2));
    chk(crcErr == (mode == 3), "R7", "crcErr flag", int'(crcErr), int'(mode == 3));
    chk(nGot == expGot, "R6", "response count", nGot, expGot);
    chk(rspBad == 0, "R6", "response data", rspBad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done pulse width", int'(done), 0);
    chk({rejected, timeout, crcErr} == {mode == 1, mode == 2, mode == 3}, "R9",
        "flags held", int'({rejected, timeout, crcErr}), int'({mode == 1, mode == 2, mode == 3}));
    highBad = 0;
    for (int i = 0; i < 4; i++) begin
      if (csN !== 1'b1) highBad++;
      @(negedge clk);
    end
    chk(highBad == 0, poke ? "R10" : "R9", "idle after frame", highBad, 0);
  endtask

  task automatic testReset();
    chk(csN == 1'b1, "R1", "csN after reset", int'(csN), 1);
    chk(busOe == 1'b0, "R1", "busOe after reset", int'(busOe), 0);
    chk({done, rejected, crcErr, timeout} == 4'b0, "R1", "flags after reset",
        int'({done, rejected, crcErr, timeout}), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) cmdMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runXfer(8'h00, 3, 1'b0, 8, 1'b0, 40, 1, 1'b0, 0, "R5");   // basic
    runXfer(8'h00, 2, 1'b0, 5, 1'b1, 40, 2, 1'b0, 3, "R7");   // bad response CRC
    runXfer(8'h00, 0, 1'b0, 12, 1'b0, 40, 3, 1'b0, 0, "R9");  // flags cleared after error
    runXfer(8'h01, 0, 1'b0, 4, 1'b0, 40, 4, 1'b0, 1, "R4");   // CRC reject code
    runXfer(8'h80, 0, 1'b0, 4, 1'b0, 40, 5, 1'b0, 1, "R4");   // other non-zero status
    runXfer(8'h00, 10, 1'b0, 3, 1'b0, 11, 6, 1'b0, 2, "R8");  // one cycle too late
    runXfer(8'h00, 10, 1'b0, 3, 1'b0, 12, 7, 1'b0, 0, "R8");  // marker on last allowed cycle
    runXfer(8'h00, 4, 1'b1, 6, 1'b0, 40, 8, 1'b0, 0, "R5");   // lone high is not a marker
    runXfer(8'h00, 1, 1'b0, 1, 1'b0, 40, 9, 1'b0, 0, "R6");   // single byte
    runXfer(8'h00, 1, 1'b0, 0, 1'b0, 40, 10, 1'b0, 0, "R6");  // empty response
    runXfer(8'h00, 2, 1'b0, 7, 1'b0, 40, 11, 1'b1, 0, "R10"); // start pulsed mid-frame
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule